// File: doc/BRIEF.md
# Banked Register Mode Switcher

This block keeps the mode-dependent part of a 32-bit processor register file: the registers 8 to 14 that change with the operating mode, the current status word, and one saved status word for each privileged mode. Around it sit an instruction decoder, an ALU and a memory port. Those parts reach registers 8–14 through one read port and one write port. Both ports always resolve to the copy that belongs to the current mode. Nothing is copied between banks. Each physical copy is stored once, and the mode field selects which copy is visible. A mode change therefore takes effect in the same clock edge that changes the status word.

The block handles exception entry. One request bit exists per exception kind, and reset is one of them. When several bits are set together, a fixed priority picks one. The block then switches mode, saves the old status, stores the return PC in the new mode's register 14 and updates the mask bits. For one cycle it presents the vector address together with a PC-load strobe. A return strobe copies the current mode's saved status back into the status word, and the banks follow the restored mode field. The surrounding core can also write the status word directly.

Top module: `mode_bank_regs`

## Requirements
- R1: An asynchronous reset (rst_n low), or a reset request (exc_req bit 0), clears every banked register and every saved status to zero and sets the status to 0x000000D3 (supervisor mode, I=1, F=0x40 set). The reset request also gives pc_load=1 with vec_addr=0 in the following cycle. The asynchronous reset does not.
- R2: The request bits exc_req[6:1] are undefined, software interrupt, prefetch abort, data abort, IRQ and FIQ. They enter modes UND/SVC/ABT/ABT/IRQ/FIQ at vectors 0x04/0x08/0x0C/0x10/0x18/0x1C. The mode field status[4:0] encodes USR=10000, FIQ=10001, IRQ=10010, SVC=10011, ABT=10111, UND=11011, SYS=11111.
- R3: On exception entry, the new mode's saved status receives the old status word. Status bits 31:8 are kept. T (bit 5) is cleared and I (bit 7) is set. F (bit 6) is set when entering FIQ and is otherwise left unchanged.
- R4: On exception entry, the new mode's register 14 receives ret_pc.
- R5: When several request bits are set, the priority is reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R6: USR and SYS share one register 13/14 pair. SVC, ABT, UND and IRQ each have a private register 13, register 14 and saved status. In USR and SYS, saved_status reads 0.
- R7: FIQ has private registers 8–12. All other modes share the user copies of registers 8–12, and those copies are unchanged by a stay in FIQ.
- R8: A return strobe loads the status from the current saved status, and register accesses then follow the restored mode. In USR or SYS the return strobe is ignored.
- R9: A register write is ignored in any cycle that takes an exception or a return. Write index values outside 8–14 are ignored, and reads of those index values return 0.
- R10: All results of an exception or a return appear one clock after the request. pc_load is high for exactly that one cycle.
- R11: A status write (st_we) replaces the whole status word. The bank selection follows the new mode, and no stored register value changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_req | input | 7 | Exception request bits: reset, undef, swi, pabt, dabt, irq, fiq (bit 0 to 6) |
| rfe | input | 1 | Return-from-exception strobe |
| ret_pc | input | 32 | Return PC stored into register 14 of the new mode |
| rd_idx | input | 4 | Read register index (8–14 valid) |
| rd_data | output | 32 | Read data for the current mode |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Write register index (8–14 valid) |
| wr_data | input | 32 | Register write data |
| st_we | input | 1 | Status word write enable |
| st_wdata | input | 32 | Status word write data |
| status | output | 32 | Current status word |
| saved_status | output | 32 | Saved status of the current mode |
| vec_addr | output | 32 | Vector address of the last exception taken |
| pc_load | output | 1 | One-cycle strobe to load vec_addr into the PC |

## Verification
Exception entry, return and status writes all act on a clock edge. The new status, the saved status, pc_load and vec_addr are due in the cycle that follows the request. The bench raises a request on a falling edge and removes it on the next falling edge, so one rising edge falls in between. Its expectations on status and strobe are queued for the falling edge that follows that rising edge. Reads are combinational from the current state: the bench sets rd_idx and checks rd_data in the same half cycle. The next cycle's read also confirms that pc_load has fallen back to zero.

// File: rtl/mode_bank_regs.sv
module mode_bank_regs #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [6:0]      exc_req,
  input  logic            rfe,
  input  logic [XLEN-1:0] ret_pc,
  input  logic [3:0]      rd_idx,
  output logic [XLEN-1:0] rd_data,
  input  logic            wr_en,
  input  logic [3:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            st_we,
  input  logic [XLEN-1:0] st_wdata,
  output logic [XLEN-1:0] status,
  output logic [XLEN-1:0] saved_status,
  output logic [XLEN-1:0] vec_addr,
  output logic            pc_load
);
  localparam int NBANK = 6;
  localparam int NLO   = 5;
  localparam logic [4:0] M_FIQ = 5'b10001, M_IRQ = 5'b10010, M_SVC = 5'b10011,
                         M_ABT = 5'b10111, M_UND = 5'b11011;
  localparam logic [XLEN-1:0] RST_STATUS = XLEN'(32'hD3);

  logic [XLEN-1:0] usr_lo [NLO];
  logic [XLEN-1:0] fiq_lo [NLO];
  logic [XLEN-1:0] r13_b  [NBANK];
  logic [XLEN-1:0] r14_b  [NBANK];
  logic [XLEN-1:0] spsr_b [NBANK];

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      M_FIQ:   return 3'd1;
      M_IRQ:   return 3'd2;
      M_SVC:   return 3'd3;
      M_ABT:   return 3'd4;
      M_UND:   return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  logic [2:0] cur_b;
  logic       in_fiq, has_spsr;
  assign cur_b    = bank_of(status[4:0]);
  assign in_fiq   = (cur_b == 3'd1);
  assign has_spsr = (cur_b != 3'd0);

  logic       take_exc;
  logic [4:0] new_mode;
  logic [7:0] new_vec;
  assign take_exc = |exc_req[6:1];

  always_comb begin
    new_mode = M_SVC;
    new_vec  = 8'h08;
    if (exc_req[4])      begin new_mode = M_ABT; new_vec = 8'h10; end
    else if (exc_req[6]) begin new_mode = M_FIQ; new_vec = 8'h1C; end
    else if (exc_req[5]) begin new_mode = M_IRQ; new_vec = 8'h18; end
    else if (exc_req[3]) begin new_mode = M_ABT; new_vec = 8'h0C; end
    else if (exc_req[1]) begin new_mode = M_UND; new_vec = 8'h04; end
  end

  logic [2:0] nb;
  assign nb = bank_of(new_mode);

  always_comb begin
    rd_data = '0;
    if (rd_idx >= 4'd8 && rd_idx <= 4'd12)
      rd_data = in_fiq ? fiq_lo[rd_idx[2:0]] : usr_lo[rd_idx[2:0]];
    else if (rd_idx == 4'd13) rd_data = r13_b[cur_b];
    else if (rd_idx == 4'd14) rd_data = r14_b[cur_b];
  end
  assign saved_status = has_spsr ? spsr_b[cur_b] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLO; i++) begin usr_lo[i] <= '0; fiq_lo[i] <= '0; end
      for (int i = 0; i < NBANK; i++) begin
        r13_b[i] <= '0; r14_b[i] <= '0; spsr_b[i] <= '0;
      end
      status   <= RST_STATUS;
      vec_addr <= '0;
      pc_load  <= 1'b0;
    end else if (exc_req[0]) begin
      for (int i = 0; i < NLO; i++) begin usr_lo[i] <= '0; fiq_lo[i] <= '0; end
      for (int i = 0; i < NBANK; i++) begin
        r13_b[i] <= '0; r14_b[i] <= '0; spsr_b[i] <= '0;
      end
      status   <= RST_STATUS;
      vec_addr <= '0;
      pc_load  <= 1'b1;
    end else begin
      pc_load <= 1'b0;
      if (take_exc) begin
        spsr_b[nb] <= status;
        r14_b[nb]  <= ret_pc;
        status     <= {status[XLEN-1:8], 1'b1, status[6] | (new_mode == M_FIQ), 1'b0, new_mode};
        vec_addr   <= XLEN'(new_vec);
        pc_load    <= 1'b1;
      end else if (rfe) begin
        if (has_spsr) status <= spsr_b[cur_b];
      end else begin
        if (st_we) status <= st_wdata;
        if (wr_en) begin
          if (wr_idx >= 4'd8 && wr_idx <= 4'd12) begin
            if (in_fiq) fiq_lo[wr_idx[2:0]] <= wr_data;
            else        usr_lo[wr_idx[2:0]] <= wr_data;
          end else if (wr_idx == 4'd13) r13_b[cur_b] <= wr_data;
          else if (wr_idx == 4'd14)     r14_b[cur_b] <= wr_data;
        end
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req[0] |=> (status == RST_STATUS && pc_load && vec_addr == '0));
  assert_vector_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (vec_addr[1:0] == 2'b00 && vec_addr <= XLEN'(32'h1C)));
  assert_entry_masks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && vec_addr != '0) |-> (status[7] && !status[5]));
  assert_fiq_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && status[4:0] == M_FIQ) |-> status[6]);
  assert_rfe_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe && exc_req == '0 && has_spsr) |=> (status == $past(saved_status)));
  assert_pc_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req != '0) |=> pc_load);
  assert_pc_strobe_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req == '0) |=> !pc_load);
endmodule

// File: tb/mode_bank_regs_test.sv
module mode_bank_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  exc_req = '0;
  logic        rfe = 1'b0;
  logic [31:0] ret_pc = '0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        st_we = 1'b0;
  logic [31:0] st_wdata = '0;
  logic [31:0] status, saved_status, vec_addr;
  logic        pc_load;

  mode_bank_regs uut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .rfe(rfe), .ret_pc(ret_pc),
    .rd_idx(rd_idx), .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .st_we(st_we), .st_wdata(st_wdata), .status(status),
    .saved_status(saved_status), .vec_addr(vec_addr), .pc_load(pc_load)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string       req;
    int          sel;
    logic [31:0] exp;
  } item_t;
  item_t q[$];
  int checks = 0, failures = 0;
  bit done = 0;

  localparam int S_ST = 0, S_SV = 1, S_RD = 2, S_VEC = 3, S_PCL = 4;

  task automatic expect_val(input int sel, input logic [31:0] exp, input string req);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.sel)
        S_ST:    act = status;
        S_SV:    act = saved_status;
        S_RD:    act = rd_data;
        S_VEC:   act = vec_addr;
        default: act = {31'd0, pc_load};
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s sel=%0d actual=%08h expected=%08h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic idle();
    exc_req = '0; rfe = 1'b0; wr_en = 1'b0; st_we = 1'b0;
  endtask

  task automatic exc(input logic [6:0] bits, input logic [31:0] pc);
    exc_req = bits; ret_pc = pc;
    @(negedge clk); idle();
  endtask

  task automatic wreg(input logic [3:0] idx, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk); idle();
  endtask

  task automatic wst(input logic [31:0] d);
    st_we = 1'b1; st_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic do_rfe();
    rfe = 1'b1;
    @(negedge clk); idle();
  endtask

  task automatic rd(input logic [3:0] idx, input logic [31:0] exp, input string req);
    rd_idx = idx;
    expect_val(S_RD, exp, req);
    @(negedge clk);
  endtask

  task automatic entry(input logic [31:0] st, input logic [31:0] sv,
                       input logic [31:0] v, input string req);
    expect_val(S_ST, st, req);
    expect_val(S_SV, sv, req);
    expect_val(S_VEC, v, req);
    expect_val(S_PCL, 32'd1, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 after asynchronous reset
    expect_val(S_ST, 32'hD3, "R1");
    expect_val(S_PCL, 32'd0, "R1");
    expect_val(S_SV, 32'h0, "R1");
    rd(4'd13, 32'h0, "R1");

    wreg(4'd13, 32'h5C0);
    wreg(4'd8, 32'h88);
    wst(32'h10);
    expect_val(S_ST, 32'h10, "R11");
    expect_val(S_SV, 32'h0, "R6");
    wreg(4'd13, 32'h1111);
    wreg(4'd14, 32'h2222);
    rd(4'd8, 32'h88, "R7");
    wst(32'hA000003F);
    rd(4'd13, 32'h1111, "R6");
    rd(4'd14, 32'h2222, "R6");

    // R2/R3/R4: IRQ from SYS
    exc(7'b0100000, 32'h100);
    entry(32'hA0000092, 32'hA000003F, 32'h18, "R3");
    rd(4'd14, 32'h100, "R4");
    expect_val(S_PCL, 32'd0, "R10");
    rd(4'd13, 32'h0, "R6");
    rd(4'd8, 32'h88, "R7");
    wreg(4'd13, 32'h1300);

    // FIQ entry
    exc(7'b1000000, 32'h200);
    entry(32'hA00000D1, 32'hA0000092, 32'h1C, "R3");
    rd(4'd8, 32'h0, "R7");
    wreg(4'd8, 32'hF8);
    rd(4'd8, 32'hF8, "R7");
    rd(4'd14, 32'h200, "R4");

    // Return from FIQ
    do_rfe();
    expect_val(S_ST, 32'hA0000092, "R8");
    rd(4'd8, 32'h88, "R7");
    rd(4'd13, 32'h1300, "R8");

    // R5 priority chain
    exc(7'b1111000, 32'h300);
    entry(32'hA0000097, 32'hA0000092, 32'h10, "R5");
    exc(7'b1101110, 32'h304);
    entry(32'hA00000D1, 32'hA0000097, 32'h1C, "R5");
    exc(7'b0001110, 32'h308);
    entry(32'hA00000D7, 32'hA00000D1, 32'h0C, "R5");
    rd(4'd14, 32'h308, "R4");
    exc(7'b0000110, 32'h30C);
    entry(32'hA00000DB, 32'hA00000D7, 32'h04, "R5");
    exc(7'b0000100, 32'h310);
    entry(32'hA00000D3, 32'hA00000DB, 32'h08, "R2");
    rd(4'd13, 32'h5C0, "R6");

    // R9 write ignored during exception
    wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'hDEAD;
    exc(7'b0000010, 32'h400);
    entry(32'hA00000DB, 32'hA00000D3, 32'h04, "R9");
    do_rfe();
    expect_val(S_ST, 32'hA00000D3, "R8");
    rd(4'd13, 32'h5C0, "R9");
    wreg(4'd3, 32'hBEEF);
    rd(4'd3, 32'h0, "R9");

    // R8 return ignored in SYS
    wst(32'h1F);
    do_rfe();
    expect_val(S_ST, 32'h1F, "R8");
    rd(4'd13, 32'h1111, "R8");

    // R1 reset request
    exc(7'b0100001, 32'h500);
    entry(32'hD3, 32'h0, 32'h0, "R1");
    rd(4'd13, 32'h0, "R1");
    rd(4'd8, 32'h0, "R1");
    wst(32'h10);
    rd(4'd14, 32'h0, "R1");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule